// File: doc/BRIEF.md
# Circulating Shift-Loop Content-Addressable Memory

This block keeps its words in a ring of shift registers. One word sits at the head (the read point) in each clock, and the ring turns by one word every cycle. A single shared comparator watches the head word. A search latches a key and a per-bit compare mask. It then observes exactly one full turn of the ring, which is DEPTH cycles, and reports every position whose word matches.

A position counter advances modulo DEPTH in step with the ring. It names the word currently at the head, so each match strobe carries the index of the word that matched. A write latches a target index and a data word. It waits until that index reaches the head, and then puts the new data into the ring in place of the old word.

The block runs one operation at a time. Requests that arrive while it is busy are dropped. If a write and a search are requested together while the block is idle, the write is taken.

Top module: `shift_loop_cam`

## Requirements
- R1: After reset, `busy`, `matchValid` and `searchDone` are low, and every stored word is zero.
- R2: A search accepted at a clock edge pulses `searchDone` high for exactly one cycle, right after the DEPTH-th following rising edge. The search can start at any ring phase.
- R3: During a search, every position whose word matches produces exactly one single-cycle `matchValid` pulse with `matchIdx` equal to that position. Positions that do not match produce no pulse.
- R4: A word matches when `((word ^ key) & mask) == 0`. A mask bit of 1 compares that bit, and a mask bit of 0 never causes a mismatch.
- R5: A write replaces only the word at `writeAddr` with `writeData`. All other words are left unchanged.
- R6: When `writeReq` and `searchReq` are both high in an idle cycle, the write is accepted and the search is dropped, so no `searchDone` follows.
- R7: Requests made while `busy` is high are ignored. They neither abort the running operation nor change any stored word, and a search produces exactly one `searchDone`.
- R8: `busy` goes high at the edge that accepts a request. For a write, `busy` returns low no more than DEPTH cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| searchReq | input | 1 | Start a search (taken when idle) |
| writeReq | input | 1 | Start a write (taken when idle, wins over search) |
| key | input | WIDTH | Search key, latched at accept |
| mask | input | WIDTH | Compare mask, 1 = compare bit |
| writeAddr | input | $clog2(DEPTH) | Target position of a write |
| writeData | input | WIDTH | Word to store |
| busy | output | 1 | Operation in progress |
| matchValid | output | 1 | One-cycle strobe for a matching position |
| matchIdx | output | $clog2(DEPTH) | Position of the matching word |
| searchDone | output | 1 | One-cycle pulse when the search ends |

## Verification
Let edge E be the clock edge that accepts a search. The comparison made in the k-th search cycle after E shows up as a strobe after edge E+k+1. The done pulse appears after edge E+DEPTH. A write has completed by edge E+DEPTH.

The bench samples outputs on falling edges and keeps a cycle count. Each search pushes onto a scoreboard queue the set of positions expected to hit and the cycle in which done is due. A monitor checks each strobe against the head entry of that queue. When done arrives, the monitor compares the arrival cycle and the full set of strobed positions with that entry.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef struct packed {
    logic cmpEn;    // head word is compared this cycle
    logic wrEn;     // head word is replaced this cycle
    logic loadKey;  // capture key and mask
    logic loadWr;   // capture write target and data
  } camCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_WRITE  = 2'd2
  } camState_t;
endpackage

// File: rtl/cam_ring_dp.sv
module cam_ring_dp
  import cam_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  camCtl_t          ctl,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] mask,
  input  logic [IW-1:0]    writeAddr,
  input  logic [WIDTH-1:0] writeData,
  output logic             atTarget,
  output logic             matchValid,
  output logic [IW-1:0]    matchIdx
);
  localparam logic [IW-1:0] LAST_POS = IW'(DEPTH - 1);

  logic [WIDTH-1:0] ring [DEPTH];
  logic [IW-1:0]    pos;
  logic [WIDTH-1:0] keyQ, maskQ, wDataQ;
  logic [IW-1:0]    wAddrQ;
  logic             headHit;

  assign atTarget = (pos == wAddrQ);
  assign headHit  = (((ring[0] ^ keyQ) & maskQ) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else begin
      pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
    end
  end

  // ring[j] holds the word of position pos+j (mod DEPTH)
  generate
    for (genvar j = 0; j < DEPTH; j++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ring[j] <= '0;
        end else if (j == DEPTH - 1) begin
          ring[j] <= ctl.wrEn ? wDataQ : ring[0];
        end else begin
          ring[j] <= ring[(j + 1) % DEPTH];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyQ   <= '0;
      maskQ  <= '0;
      wDataQ <= '0;
      wAddrQ <= '0;
    end else begin
      if (ctl.loadKey) begin
        keyQ  <= key;
        maskQ <= mask;
      end
      if (ctl.loadWr) begin
        wAddrQ <= writeAddr;
        wDataQ <= writeData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      matchValid <= 1'b0;
      matchIdx   <= '0;
    end else begin
      matchValid <= ctl.cmpEn && headHit;
      matchIdx   <= pos;
    end
  end

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pos == (($past(pos) == LAST_POS) ? '0 : $past(pos) + 1'b1)); // R3
  AST_STROBE_IN_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    matchValid |-> $past(ctl.cmpEn)); // R3
  AST_WRITE_AT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wrEn |-> atTarget && !ctl.cmpEn); // R5
endmodule

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    searchReq,
  input  logic    writeReq,
  input  logic    atTarget,
  output camCtl_t ctl,
  output logic    busy,
  output logic    searchDone
);
  localparam logic [CW-1:0] LAST_CNT = CW'(DEPTH - 1);

  camState_t     state;
  logic [CW-1:0] cnt;

  assign busy = (state != ST_IDLE);

  always_comb begin
    ctl         = '0;
    ctl.loadWr  = (state == ST_IDLE) && writeReq;
    ctl.loadKey = (state == ST_IDLE) && searchReq && !writeReq;
    ctl.cmpEn   = (state == ST_SEARCH);
    ctl.wrEn    = (state == ST_WRITE) && atTarget;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      searchDone <= 1'b0;
    end else begin
      searchDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (writeReq)       state <= ST_WRITE;
          else if (searchReq) state <= ST_SEARCH;
        end
        ST_SEARCH: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) begin
            state      <= ST_IDLE;
            searchDone <= 1'b1;
          end
        end
        ST_WRITE: begin
          cnt <= cnt + 1'b1;
          if (atTarget) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    searchDone |=> !searchDone); // R2
  AST_SEARCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH && cnt != LAST_CNT) |=> state == ST_SEARCH); // R7
  AST_WRITE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WRITE && cnt == LAST_CNT) |-> atTarget); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && writeReq) |=> state == ST_WRITE); // R6
endmodule

// File: rtl/shift_loop_cam.sv
module shift_loop_cam
  import cam_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             searchReq,
  input  logic             writeReq,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] mask,
  input  logic [IW-1:0]    writeAddr,
  input  logic [WIDTH-1:0] writeData,
  output logic             busy,
  output logic             matchValid,
  output logic [IW-1:0]    matchIdx,
  output logic             searchDone
);
  camCtl_t ctl;
  logic    atTarget;

  cam_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .searchReq(searchReq), .writeReq(writeReq),
    .atTarget(atTarget), .ctl(ctl), .busy(busy), .searchDone(searchDone)
  );

  cam_ring_dp #(.WIDTH(WIDTH), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .key(key), .mask(mask),
    .writeAddr(writeAddr), .writeData(writeData), .atTarget(atTarget),
    .matchValid(matchValid), .matchIdx(matchIdx)
  );

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    searchDone |-> !busy && $past(busy)); // R2
endmodule

// File: tb/shift_loop_cam_tb_top.sv
module shift_loop_cam_tb_top;
  localparam int W  = 32;
  localparam int D  = 32;
  localparam int IW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic searchReq = 1'b0, writeReq = 1'b0;
  logic [W-1:0] key = '0, mask = '0, writeData = '0;
  logic [IW-1:0] writeAddr = '0;
  logic busy, matchValid, searchDone;
  logic [IW-1:0] matchIdx;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct { logic [D-1:0] hits; int due; } item_t;
  item_t sbQ[$];
  logic [D-1:0] seen;
  logic [W-1:0] model [D];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shift_loop_cam #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .searchReq(searchReq), .writeReq(writeReq),
    .key(key), .mask(mask), .writeAddr(writeAddr), .writeData(writeData),
    .busy(busy), .matchValid(matchValid), .matchIdx(matchIdx),
    .searchDone(searchDone)
  );

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (matchValid) begin
        checks++;
        if (sbQ.size() == 0) begin
          errors++;
          $display("FAIL R3: strobe idx %0d with no search pending (expected none)", matchIdx);
        end else if (!sbQ[0].hits[matchIdx] || seen[matchIdx]) begin
          errors++;
          $display("FAIL R3/R4: strobe idx %0d seen=%0b expected hit=%0b", matchIdx,
                   seen[matchIdx], sbQ[0].hits[matchIdx]);
        end
        seen[matchIdx] = 1'b1;
      end
      if (searchDone) begin
        checks++;
        if (sbQ.size() == 0) begin
          errors++;
          $display("FAIL R6/R7: searchDone=1 expected 0 (no search accepted)");
        end else begin
          item_t it;
          it = sbQ.pop_front();
          if (cyc != it.due) begin
            errors++;
            $display("FAIL R2: done at cycle %0d expected %0d", cyc, it.due);
          end
          checks++;
          if (seen != it.hits) begin
            errors++;
            $display("FAIL R3: hit set %h expected %h", seen, it.hits);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [D-1:0] expHits(input logic [W-1:0] k, input logic [W-1:0] m);
    logic [D-1:0] h;
    for (int i = 0; i < D; i++) h[i] = (((model[i] ^ k) & m) == '0);
    return h;
  endfunction

  // Driver: start a search, push the expected item (no wait for end)
  task automatic startSearch(input logic [W-1:0] k, input logic [W-1:0] m);
    item_t it;
    while (busy) @(negedge clk);
    key = k; mask = m; searchReq = 1'b1;
    @(negedge clk);
    searchReq = 1'b0;
    check(busy, "R8 search busy", busy, 1);
    it.hits = expHits(k, m);
    it.due  = cyc + D;
    seen = '0;
    sbQ.push_back(it);
  endtask

  task automatic doSearch(input logic [W-1:0] k, input logic [W-1:0] m);
    startSearch(k, m);
    while (busy) @(negedge clk);
  endtask

  task automatic doWrite(input logic [IW-1:0] a, input logic [W-1:0] d, input bit alsoSearch);
    int n;
    while (busy) @(negedge clk);
    writeAddr = a; writeData = d; writeReq = 1'b1; searchReq = alsoSearch;
    @(negedge clk);
    writeReq = 1'b0; searchReq = 1'b0;
    check(busy, "R8 write busy", busy, 1);
    n = 0;
    while (busy) begin
      @(negedge clk);
      n++;
    end
    check(n <= D, "R8 write latency", n, D);
    model[a] = d;
  endtask

  initial begin
    for (int i = 0; i < D; i++) model[i] = '0;
    seen = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1 busy", busy, 0);
    check(!matchValid, "R1 matchValid", matchValid, 0);
    check(!searchDone, "R1 searchDone", searchDone, 0);
    // R1: all words zero -> every position hits
    doSearch('0, '1);

    // R5: writes, exact searches for single words
    doWrite(5'd0,  32'hDEAD_BEEF, 1'b0);
    doWrite(5'd5,  32'h1234_5678, 1'b0);
    doWrite(IW'(D-1), 32'hCAFE_0001, 1'b0);
    doWrite(5'd17, 32'h1234_00AA, 1'b0);
    doSearch(32'hDEAD_BEEF, '1);
    doSearch(32'hCAFE_0001, '1);
    doSearch(32'h1234_5678, '1);
    // R4: partial masks
    doSearch(32'h1234_FFFF, 32'hFFFF_0000);
    doSearch(32'h0000_0001, 32'h0000_000F);
    doSearch(32'h5555_5555, '0);
    // R5: overwrite one word, neighbours unchanged
    doWrite(5'd5, 32'h0000_0000, 1'b0);
    doSearch(32'h1234_5678, '1);
    doSearch('0, '1);

    // R6: both requests while idle -> write wins, no done
    doWrite(5'd9, 32'hA5A5_A5A5, 1'b1);
    begin
      bit sawDone = 1'b0;
      for (int i = 0; i < D + 2; i++) begin
        @(negedge clk);
        if (searchDone) sawDone = 1'b1;
      end
      check(!sawDone, "R6 dropped search", sawDone, 0);
    end
    doSearch(32'hA5A5_A5A5, '1);

    // R7: requests during a search are ignored
    startSearch(32'h0000_00AA, 32'h0000_00FF);
    repeat (3) @(negedge clk);
    writeAddr = 5'd3; writeData = 32'h7777_7777; writeReq = 1'b1; searchReq = 1'b1;
    @(negedge clk);
    writeReq = 1'b0; searchReq = 1'b0;
    check(busy, "R7 still busy", busy, 1);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sbQ.size() == 0, "R7 queue drained", sbQ.size(), 0);
    doSearch(32'h7777_7777, '1);

    // R3: duplicate words give several strobes
    doWrite(5'd20, 32'h0BAD_F00D, 1'b0);
    doWrite(5'd21, 32'h0BAD_F00D, 1'b0);
    doWrite(5'd2,  32'h0BAD_F00D, 1'b0);
    doSearch(32'h0BAD_F00D, '1);

    repeat (4) @(negedge clk);
    check(sbQ.size() == 0, "R2 all searches done", sbQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule